// File: doc/BRIEF.md
# Single-Cycle 16-bit Load/Store Processor Core

This block is a small processor that completes one instruction on every clock edge. Each instruction is a 16-bit word with a 4-bit operation code and three 4-bit fields. The core fetches the word from a byte-wide instruction store at the program counter and reads two operands from a sixteen-entry register file. It then does one of three things: it writes an arithmetic or logic result or a loaded word back to a register, it stores a register to the word-wide data store, or it moves the program counter.

Both stores are inside the block. A load port fills them, one instruction byte or one data word per cycle, normally while reset is held. Each cycle the core shows what it is doing on trace outputs: the program counter, the fetched word, the register write strobe with its index and value, and the data store write strobe with its byte address and value. A checker or a larger system can follow execution from these outputs alone.

Top module: `tiny16_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter is set to 0 and all sixteen registers are set to 0. No register or data-store write is issued during a cycle in which `rst` is high.
- R2: `instr_o` holds the instruction at the program counter. Its bits [7:0] are the byte at address PC and its bits [15:8] are the byte at PC+1, with the address wrapping at the size of the instruction store.
- R3: Opcodes 0010 (add), 0011 (subtract Rs minus Rt), 0100 (bitwise and) and 0101 (bitwise or) write the 16-bit result of R[Rs] op R[Rt] to register Rd. The fields are Rs = bits [11:8], Rt = bits [7:4] and Rd = bits [3:0].
- R4: Opcode 0000 (load) writes the data word at byte address R[Rs] + sext(bits [3:0]) into register Rt. The offset is 4 bits, sign-extended to 16 bits.
- R5: Opcode 0001 (store) writes R[Rt] to the data word at byte address R[Rs] + sext(bits [3:0]). It writes no register.
- R6: Opcode 0111 (branch if equal) compares R[Rs] and R[Rt]. When they are equal, the next PC is PC + 2 + 2·sext(bits [3:0]). Otherwise the next PC is PC + 2. The branch writes neither a register nor the data store.
- R7: Opcode 1000 (jump) sets the next PC to 2·bits [11:0], zero-extended. It writes nothing.
- R8: Opcodes 0110 and 1001 through 1111 write nothing and advance the PC by 2.
- R9: The data store holds 16-bit words selected by byte address bits [DM_AW:1]. Address bit 0 and the bits above are ignored, so an odd address reaches the same word as the even address just below it.
- R10: After a load, a store, or any of the four ALU operations, the next PC is PC + 2, wrapping modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem | input | 1 | Write `ld_data[7:0]` into the instruction byte at `ld_addr` |
| ld_dmem | input | 1 | Write `ld_data` into the data word at byte address `ld_addr` |
| ld_addr | input | 16 | Byte address for the load port |
| ld_data | input | 16 | Load port data |
| pc_o | output | 16 | Current program counter |
| instr_o | output | 16 | Instruction fetched at the program counter |
| rf_we_o | output | 1 | A register is written at the coming edge |
| rf_waddr_o | output | 4 | Index of the register being written |
| rf_wdata_o | output | 16 | Value being written to the register |
| dm_we_o | output | 1 | The data store is written at the coming edge |
| dm_addr_o | output | 16 | Computed byte address of the data access |
| dm_wdata_o | output | 16 | Value being stored |

## Verification
Every register is zero after reset, so branch operands are equal at first, and every branch is taken until loads bring in non-zero data. The not-taken branch path, and subtraction results that are not trivial, are therefore hard to reach from the ports. The stimulus gets there by preloading the data store with distinct words, so the first loads of a program seed unequal registers. Each random program is then run long enough for its arithmetic results to spread through the register file. Odd-address accesses need an exact base-plus-offset sum. A directed program produces them with negative offsets from register 0, and then reads back through the even address a word that was stored through the odd address.

// File: rtl/tiny16_pkg.sv
`timescale 1ns/1ps
package tiny16_pkg;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned OPC_W  = 4;
   localparam int unsigned RF_AW  = 4;
   localparam int unsigned RF_N   = 1 << RF_AW;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 4'h0,
      OP_STORE = 4'h1,
      OP_ADD   = 4'h2,
      OP_SUB   = 4'h3,
      OP_AND   = 4'h4,
      OP_OR    = 4'h5,
      OP_BEQ   = 4'h7,
      OP_JUMP  = 4'h8
   } opcode_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_SUB = 2'd1,
      FN_AND = 2'd2,
      FN_OR  = 2'd3
   } alu_fn_e;

   typedef enum logic [1:0] {
      NPC_STEP = 2'd0,
      NPC_COND = 2'd1,
      NPC_ABS  = 2'd2
   } npc_sel_e;

   typedef struct packed {
      logic     rf_we;
      logic     dst_is_rt;
      logic     wb_from_mem;
      logic     b_is_imm;
      logic     dm_we;
      alu_fn_e  fn;
      npc_sel_e npc;
   } ctrl_t;

endpackage

// File: rtl/tiny16_decode.sv
`timescale 1ns/1ps
module tiny16_decode
   import tiny16_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output ctrl_t             ctrl,
   output logic [RF_AW-1:0]  rs,
   output logic [RF_AW-1:0]  rt,
   output logic [RF_AW-1:0]  rd,
   output logic [WORD_W-1:0] imm_sext,
   output logic [11:0]       jump_field
);

   logic [OPC_W-1:0] opc;

   assign opc        = instr[15:12];
   assign rs         = instr[11:8];
   assign rt         = instr[7:4];
   assign rd         = instr[3:0];
   assign imm_sext   = {{(WORD_W-4){instr[3]}}, instr[3:0]};
   assign jump_field = instr[11:0];

   always_comb begin
      ctrl     = '0;
      ctrl.fn  = FN_ADD;
      ctrl.npc = NPC_STEP;
      case (opc)
         OP_LOAD: begin
            ctrl.rf_we       = 1'b1;
            ctrl.dst_is_rt   = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.b_is_imm    = 1'b1;
         end
         OP_STORE: begin
            ctrl.dm_we    = 1'b1;
            ctrl.b_is_imm = 1'b1;
         end
         OP_ADD: begin
            ctrl.rf_we = 1'b1;
            ctrl.fn    = FN_ADD;
         end
         OP_SUB: begin
            ctrl.rf_we = 1'b1;
            ctrl.fn    = FN_SUB;
         end
         OP_AND: begin
            ctrl.rf_we = 1'b1;
            ctrl.fn    = FN_AND;
         end
         OP_OR: begin
            ctrl.rf_we = 1'b1;
            ctrl.fn    = FN_OR;
         end
         OP_BEQ: begin
            ctrl.fn  = FN_SUB;
            ctrl.npc = NPC_COND;
         end
         OP_JUMP: begin
            ctrl.npc = NPC_ABS;
         end
         default: begin
            ctrl.npc = NPC_STEP;
         end
      endcase
   end

endmodule

// File: rtl/tiny16_alu.sv
`timescale 1ns/1ps
module tiny16_alu
   import tiny16_pkg::*;
#(
   parameter int unsigned W = WORD_W
) (
   input  alu_fn_e       fn,
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [W-1:0]  y,
   output logic          zero
);

   always_comb begin
      unique case (fn)
         FN_ADD: y = a + b;
         FN_SUB: y = a - b;
         FN_AND: y = a & b;
         FN_OR:  y = a | b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/tiny16_regfile.sv
`timescale 1ns/1ps
module tiny16_regfile #(
   parameter int unsigned W  = 16,
   parameter int unsigned AW = 4,
   localparam int unsigned N = 1 << AW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);

   logic [W-1:0] cells [N];

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (we && (waddr == AW'(i))) begin
            q <= wdata;
         end
      end
      assign cells[i] = q;
   end

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/tiny16_imem.sv
`timescale 1ns/1ps
module tiny16_imem #(
   parameter int unsigned BYTES = 256,
   localparam int unsigned AW = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [15:0]   rd_word
);

   logic [7:0]    mem [BYTES];
   logic [AW-1:0] hi_addr;

   always_ff @(posedge clk) begin
      if (ld_we) begin
         mem[ld_addr] <= ld_byte;
      end
   end

   assign hi_addr = rd_addr + AW'(1);
   assign rd_word = {mem[hi_addr], mem[rd_addr]};

endmodule

// File: rtl/tiny16_dmem.sv
`timescale 1ns/1ps
module tiny16_dmem #(
   parameter int unsigned W     = 16,
   parameter int unsigned WORDS = 128,
   localparam int unsigned AW = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [W-1:0]  ld_data
);

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (ld_we) begin
         mem[ld_addr] <= ld_data;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/tiny16_core.sv
`timescale 1ns/1ps
module tiny16_core
   import tiny16_pkg::*;
#(
   parameter int unsigned IMEM_BYTES = 256,
   parameter int unsigned DMEM_WORDS = 128,
   localparam int unsigned IM_AW = $clog2(IMEM_BYTES),
   localparam int unsigned DM_AW = $clog2(DMEM_WORDS)
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        ld_imem,
   input  logic        ld_dmem,
   input  logic [15:0] ld_addr,
   input  logic [15:0] ld_data,
   output logic [15:0] pc_o,
   output logic [15:0] instr_o,
   output logic        rf_we_o,
   output logic [3:0]  rf_waddr_o,
   output logic [15:0] rf_wdata_o,
   output logic        dm_we_o,
   output logic [15:0] dm_addr_o,
   output logic [15:0] dm_wdata_o
);

   if ((IMEM_BYTES < 2) || (IMEM_BYTES > 65536) ||
       ((IMEM_BYTES & (IMEM_BYTES - 1)) != 0)) begin : g_bad_imem
      $error("IMEM_BYTES must be a power of two between 2 and 65536");
   end
   if ((DMEM_WORDS < 2) || (DMEM_WORDS > 32768) ||
       ((DMEM_WORDS & (DMEM_WORDS - 1)) != 0)) begin : g_bad_dmem
      $error("DMEM_WORDS must be a power of two between 2 and 32768");
   end

   logic [WORD_W-1:0] pc_q, pc_n, pc_step, pc_cond, pc_abs;
   logic [WORD_W-1:0] instr;
   ctrl_t             ctrl;
   logic [RF_AW-1:0]  rs, rt, rd, wdst;
   logic [WORD_W-1:0] imm_sext;
   logic [11:0]       jump_field;
   logic [WORD_W-1:0] opa, opb, alu_b, alu_y, mem_rd, wb_val;
   logic              alu_zero;
   logic              rf_we, dm_we;
   logic              unused_ld;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_n;
      end
   end

   tiny16_imem #(.BYTES(IMEM_BYTES)) u_imem (
      .clk     (clk),
      .ld_we   (ld_imem),
      .ld_addr (ld_addr[IM_AW-1:0]),
      .ld_byte (ld_data[7:0]),
      .rd_addr (pc_q[IM_AW-1:0]),
      .rd_word (instr)
   );

   tiny16_decode u_dec (
      .instr      (instr),
      .ctrl       (ctrl),
      .rs         (rs),
      .rt         (rt),
      .rd         (rd),
      .imm_sext   (imm_sext),
      .jump_field (jump_field)
   );

   assign rf_we = ctrl.rf_we & ~rst;
   assign dm_we = ctrl.dm_we & ~rst;
   assign wdst  = ctrl.dst_is_rt ? rt : rd;

   tiny16_regfile #(.W(WORD_W), .AW(RF_AW)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .waddr   (wdst),
      .wdata   (wb_val),
      .raddr_a (rs),
      .raddr_b (rt),
      .rdata_a (opa),
      .rdata_b (opb)
   );

   assign alu_b = ctrl.b_is_imm ? imm_sext : opb;

   tiny16_alu #(.W(WORD_W)) u_alu (
      .fn   (ctrl.fn),
      .a    (opa),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   tiny16_dmem #(.W(WORD_W), .WORDS(DMEM_WORDS)) u_dmem (
      .clk     (clk),
      .we      (dm_we),
      .addr    (alu_y[DM_AW:1]),
      .wdata   (opb),
      .rdata   (mem_rd),
      .ld_we   (ld_dmem),
      .ld_addr (ld_addr[DM_AW:1]),
      .ld_data (ld_data)
   );

   assign wb_val = ctrl.wb_from_mem ? mem_rd : alu_y;

   assign pc_step = pc_q + WORD_W'(2);
   assign pc_cond = pc_step + {imm_sext[WORD_W-2:0], 1'b0};
   assign pc_abs  = {3'b000, jump_field, 1'b0};

   always_comb begin
      case (ctrl.npc)
         NPC_COND: pc_n = alu_zero ? pc_cond : pc_step;
         NPC_ABS:  pc_n = pc_abs;
         default:  pc_n = pc_step;
      endcase
   end

   assign unused_ld = ^ld_addr;

   assign pc_o       = pc_q;
   assign instr_o    = instr;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = wdst;
   assign rf_wdata_o = wb_val;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = opb;

endmodule

// File: rtl/tiny16_core_chk.sv
`timescale 1ns/1ps
module tiny16_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [15:0] pc_o,
   input logic [15:0] instr_o,
   input logic        rf_we_o,
   input logic [3:0]  rf_waddr_o,
   input logic        dm_we_o
);

   logic [3:0] opc;
   logic       is_alu, is_spare;

   assign opc      = instr_o[15:12];
   assign is_alu   = (opc >= 4'h2) && (opc <= 4'h5);
   assign is_spare = (opc == 4'h6) || (opc >= 4'h9);

   // R1
   reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_o == 16'h0000));

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o));

   // R3
   alu_dest_chk: assert property (@(posedge clk) disable iff (rst)
      is_alu |-> (rf_we_o && (rf_waddr_o == instr_o[3:0]) && !dm_we_o));

   // R4
   load_dest_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h0) |-> (rf_we_o && (rf_waddr_o == instr_o[7:4]) && !dm_we_o));

   // R5
   store_only_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h1) |-> (dm_we_o && !rf_we_o));

   // R6
   branch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h7) |-> (!rf_we_o && !dm_we_o));

   // R7
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h8) |=> (pc_o == {3'b000, $past(instr_o[11:0]), 1'b0}));

   // R8
   spare_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      is_spare |-> (!rf_we_o && !dm_we_o));

   // R8
   spare_step_chk: assert property (@(posedge clk) disable iff (rst)
      is_spare |=> (pc_o == $past(pc_o) + 16'd2));

   // R10
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (opc <= 4'h5) |=> (pc_o == $past(pc_o) + 16'd2));

endmodule

bind tiny16_core tiny16_core_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .pc_o       (pc_o),
   .instr_o    (instr_o),
   .rf_we_o    (rf_we_o),
   .rf_waddr_o (rf_waddr_o),
   .dm_we_o    (dm_we_o)
);

// File: tb/tiny16_core_tb.sv
`timescale 1ns/1ps
module tiny16_core_tb;

   localparam int IMB = 256;
   localparam int DMW = 128;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_imem = 1'b0;
   logic        ld_dmem = 1'b0;
   logic [15:0] ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [15:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic        rf_we_o, dm_we_o;
   logic [3:0]  rf_waddr_o;

   always #2.5 clk = ~clk;

   tiny16_core #(.IMEM_BYTES(IMB), .DMEM_WORDS(DMW)) u_dut (
      .clk(clk), .rst(rst), .ld_imem(ld_imem), .ld_dmem(ld_dmem),
      .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
      .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
      .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
   );

   logic [7:0]  m_im [IMB];
   logic [15:0] m_dm [DMW];
   logic [15:0] m_rf [16];
   logic [15:0] m_pc;
   string       pc_tag;
   bit          fresh;
   int          vecs = 0;
   int          miss = 0;
   bit          done = 0;

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s %s: actual %h expected %h (pc %h)", tag, what, act, exp, m_pc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   endtask

   function automatic logic [15:0] enc(input logic [3:0] o, input logic [3:0] s,
                                       input logic [3:0] t, input logic [3:0] d);
      return {o, s, t, d};
   endfunction

   task automatic put(input int addr, input logic [15:0] w);
      m_im[addr % IMB]       = w[7:0];
      m_im[(addr + 1) % IMB] = w[15:8];
   endtask

   // Load both stores through the load port while reset is held (R1).
   task automatic load_and_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < IMB; i++) begin
         ld_imem = 1'b1; ld_addr = 16'(i); ld_data = {8'h00, m_im[i]};
         @(negedge clk);
      end
      ld_imem = 1'b0;
      for (int i = 0; i < DMW; i++) begin
         ld_dmem = 1'b1; ld_addr = 16'(i * 2); ld_data = m_dm[i];
         @(negedge clk);
      end
      ld_dmem = 1'b0;
      @(negedge clk);
      #1;
      chk("R1", "rf_we in reset", {15'd0, rf_we_o}, 16'd0);
      chk("R1", "dm_we in reset", {15'd0, dm_we_o}, 16'd0);
      @(negedge clk);
      for (int r = 0; r < 16; r++) m_rf[r] = 16'h0000;
      m_pc   = 16'h0000;
      pc_tag = "R1";
      fresh  = 1;
      rst    = 1'b0;
   endtask

   task automatic step_and_check();
      logic [7:0]  lo, hi;
      logic [15:0] ins, a, b, off, ea, wd, nxt;
      logic [3:0]  op, s, t, d, wa;
      logic        we, dwe;
      string       tg, ntag;
      lo  = m_pc[7:0];
      hi  = lo + 8'd1;
      ins = {m_im[hi], m_im[lo]};
      op = ins[15:12]; s = ins[11:8]; t = ins[7:4]; d = ins[3:0];
      a   = m_rf[s];
      b   = m_rf[t];
      off = {{12{d[3]}}, d};
      ea  = a + off;
      we = 0; dwe = 0; wa = 0; wd = 0;
      nxt  = m_pc + 16'd2;
      ntag = "R10";
      case (op)
         4'h0: begin we = 1; wa = t; wd = m_dm[ea[7:1]]; tg = ea[0] ? "R9" : "R4"; end
         4'h1: begin dwe = 1; tg = ea[0] ? "R9" : "R5"; end
         4'h2: begin we = 1; wa = d; wd = a + b; tg = "R3"; end
         4'h3: begin we = 1; wa = d; wd = a - b; tg = "R3"; end
         4'h4: begin we = 1; wa = d; wd = a & b; tg = "R3"; end
         4'h5: begin we = 1; wa = d; wd = a | b; tg = "R3"; end
         4'h7: begin
            tg = "R6"; ntag = "R6";
            if (a == b) nxt = m_pc + 16'd2 + {off[14:0], 1'b0};
         end
         4'h8: begin tg = "R7"; ntag = "R7"; nxt = {3'b000, ins[11:0], 1'b0}; end
         default: begin tg = "R8"; ntag = "R8"; end
      endcase
      if (fresh && we) tg = "R1";
      chk(pc_tag, "pc", pc_o, m_pc);
      chk("R2", "instr", instr_o, ins);
      chk(tg, "rf_we", {15'd0, rf_we_o}, {15'd0, we});
      if (we) begin
         chk(tg, "rf_waddr", {12'd0, rf_waddr_o}, {12'd0, wa});
         chk(tg, "rf_wdata", rf_wdata_o, wd);
      end
      chk(tg, "dm_we", {15'd0, dm_we_o}, {15'd0, dwe});
      if (dwe) begin
         chk(tg, "dm_addr", dm_addr_o, ea);
         chk(tg, "dm_wdata", dm_wdata_o, b);
      end
      if (we) m_rf[wa] = wd;
      if (dwe) m_dm[ea[7:1]] = b;
      m_pc   = nxt;
      pc_tag = ntag;
      fresh  = 0;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) begin
         #1;
         step_and_check();
         @(negedge clk);
      end
   endtask

   initial begin
      // Directed program: every opcode, odd addresses, branches both ways.
      for (int i = 0; i < IMB; i++) m_im[i] = 8'h00;
      for (int i = 0; i < DMW; i++) m_dm[i] = 16'(i * 16'h0111);
      m_dm[0]   = 16'h1234;
      m_dm[1]   = 16'h8001;
      m_dm[127] = 16'h0A0A;
      put(0,  enc(4'h5, 4'd7, 4'd9, 4'd1));   // OR zeros right after reset (R1)
      put(2,  enc(4'h0, 4'd0, 4'd4, 4'd2));   // LW r4, 2(r0)
      put(4,  enc(4'h0, 4'd0, 4'd5, 4'd0));   // LW r5, 0(r0)
      put(6,  enc(4'h2, 4'd4, 4'd5, 4'd6));   // ADD
      put(8,  enc(4'h3, 4'd5, 4'd4, 4'd7));   // SUB
      put(10, enc(4'h4, 4'd4, 4'd5, 4'd8));   // AND
      put(12, enc(4'h5, 4'd4, 4'd5, 4'd9));   // OR
      put(14, enc(4'h0, 4'd0, 4'd10, 4'hF));  // LW at 0xFFFF, odd (R9)
      put(16, enc(4'h1, 4'd0, 4'd6, 4'd3));   // SW at 3, odd (R9)
      put(18, enc(4'h0, 4'd0, 4'd11, 4'd2));  // LW at 2 reads the word stored at 3
      put(20, 16'h6ABC);                      // spare opcode (R8)
      put(22, 16'hF123);                      // spare opcode (R8)
      put(24, enc(4'h7, 4'd4, 4'd4, 4'd2));   // BEQ taken forward
      put(26, enc(4'h2, 4'd4, 4'd4, 4'd12));
      put(28, enc(4'h2, 4'd4, 4'd4, 4'd13));
      put(30, enc(4'h7, 4'd4, 4'd5, 4'hC));   // BEQ not taken
      put(32, {4'h8, 12'd20});                // JMP to 40
      put(34, enc(4'h1, 4'd6, 4'd9, 4'hE));   // SW with negative offset
      put(36, {4'h8, 12'd48});                // JMP to 96
      put(40, enc(4'h7, 4'd1, 4'd0, 4'hC));   // BEQ taken backward to 34
      put(96, 16'h9000);
      put(98, {4'h8, 12'd0});                 // wrap back to 0
      load_and_reset();
      run(60);

      // Random programs, each behind a fresh reset and preload.
      for (int round = 0; round < 8; round++) begin
         for (int i = 0; i < IMB; i += 2) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (w[15:12] == 4'h8) w[11:0] = 12'($urandom % (IMB / 2));
            put(i, w);
         end
         for (int i = 0; i < DMW; i++) m_dm[i] = 16'($urandom);
         load_and_reset();
         run(300);
      end
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      vecs++;
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule